// File: doc/BRIEF.md
# Oversampled Serial Pattern Detector

This block listens to a single serial data wire that carries no clock of its own. A local receive clock runs at four times the bit rate. The wire is first brought into the receive clock domain through a short flip-flop chain. While the wire stays high the block is idle. A low level does not start reception until it is confirmed by a second look two receive clocks later. A low that does not last that long is thrown away as a glitch.

Once a start bit is confirmed, the block raises a one-cycle start flag. It then samples the wire once every four receive clocks, near the centre of each bit, and shifts each sample into a four-bit history. Whenever the history equals a 4-bit code on the pattern input, a one-cycle match flag is raised. Overlapping occurrences count. A run of four one-valued data samples means the sender has stopped, and the block falls back to idle and waits for the next start bit.

Top module: `serial_pattern_rx`

## Requirements
- R1: A synchronous active-high reset returns the block to idle, clears the history and the sample timing, and holds `start_o` and `match_o` low. A stream that was being received before the reset produces no flag afterwards.
- R2: While the line stays high, the block stays idle and `start_o` never rises.
- R3: After the first low sample in idle, the line is sampled again two receive clocks later. A low pulse on `rx_line` that lasts two receive clocks or less is rejected as a glitch: no start flag, and the block is idle again.
- R4: A confirmed start raises `start_o` for exactly one cycle. If `rx_line` falls just before rising edge 1, `start_o` is high from rising edge 5 up to rising edge 6.
- R5: After a confirmed start, data bit j (j = 1, 2, ...) is sampled four receive clocks after the previous sample. Any match flag for bit j is high in the single cycle that begins 4*j clocks after `start_o` rose.
- R6: `match_o` is high for exactly one cycle when the four most recent data bits equal `pattern_i`. The earliest of the four bits is compared with `pattern_i[3]` and the newest with `pattern_i[0]`.
- R7: Overlapping matches are all reported. With pattern 0110, the data 01101101101 gives a pulse at data bits 4, 7 and 10.
- R8: The start bit never enters the history. The history is cleared at each new start, so `match_o` cannot rise before the fourth data bit of a frame. For example, pattern 0000 with data 000000 matches at data bits 4, 5 and 6 only.
- R9: Four consecutive one-valued data samples return the block to idle. A low line right after the fourth one is taken as a new start bit.
- R10: `pattern_i` is read at each data sample, so any of the 16 codes can be matched, including 1111 on the ending run of ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, four times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, high when no data is sent |
| pattern_i | input | 4 | Code to match; bit 3 is the earliest received bit |
| start_o | output | 1 | One-cycle flag when a start bit is confirmed |
| match_o | output | 1 | One-cycle flag when the last four data bits equal the code |

## Verification
The assertions check on every cycle that both flags last one cycle, that a start flag only follows the qualify state, and that the qualify wait stays within its two-clock bound. They also check that a match needs a full history and that a completed run of ones forces idle on the next edge. Only the bench's scenarios can show the exact cycle at which each flag appears relative to the line's edges. The same holds for glitch rejection at the two- and three-clock boundary, the positions of overlapping matches for several codes, and a new frame starting straight after the ending run of ones.

// File: rtl/spd_pkg.sv
package spd_pkg;

    localparam int OVS_RATIO  = 4;   // receive clocks per bit
    localparam int PATTERN_W  = 4;   // bits compared
    localparam int SYNC_DEPTH = 2;   // synchronizer flops
    localparam int END_RUN    = 4;   // ones that end a stream

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_QUAL = 2'd1,
        ST_RECV = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic confirm;   // start bit accepted this cycle
        logic sample;    // data bit taken this cycle
    } seq_ctl_t;

    function automatic int sat_inc(input int value, input int limit);
        return (value >= limit) ? limit : value + 1;
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int STAGES = spd_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;   // line rests high
                else     chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rx_sequencer.sv
module rx_sequencer
    import spd_pkg::*;
#(
    parameter int OVS = OVS_RATIO
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      line_s,
    input  logic      stop_req,
    output seq_ctl_t  ctl,
    output logic      start_flag
);
    localparam int CW        = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int QUAL_LAST = OVS / 2 - 1;

    rx_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           start_q;
    seq_ctl_t       ctl_d;

    always_comb begin
        state_d       = state_q;
        cnt_d         = cnt_q;
        ctl_d         = '0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (!line_s) state_d = ST_QUAL;
            end
            ST_QUAL: begin
                if (cnt_q == CW'(QUAL_LAST)) begin
                    cnt_d = '0;
                    if (!line_s) begin
                        state_d       = ST_RECV;
                        ctl_d.confirm = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RECV: begin
                if (cnt_q == CW'(OVS - 1)) begin
                    cnt_d        = '0;
                    ctl_d.sample = 1'b1;
                    if (stop_req) state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            start_q <= ctl_d.confirm;
        end
    end

    assign ctl        = ctl_d;
    assign start_flag = start_q;

    // R4: start flag is a single-cycle pulse
    a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

    // R4: start flag only follows the qualify state
    a_r4_start_from_qual: assert property (@(posedge clk) disable iff (rst)
        start_q |-> $past(state_q) == ST_QUAL);

    // R3: qualify wait never exceeds its bound
    a_r3_qual_bounded: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_QUAL) |-> (cnt_q <= CW'(QUAL_LAST)));

    // R5: data samples are never back to back
    a_r5_sample_spacing: assert property (@(posedge clk) disable iff (rst)
        ctl_d.sample |=> !ctl_d.sample);

    // R9: completed run of ones forces idle
    a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        (ctl_d.sample && stop_req) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/bit_history.sv
module bit_history
    import spd_pkg::*;
#(
    parameter int PAT_W    = PATTERN_W,
    parameter int RUN_LEN  = END_RUN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             sample,
    input  logic             bit_i,
    input  logic [PAT_W-1:0] pattern_i,
    output logic             match_o,
    output logic             stop_o
);
    localparam int FW = $clog2(PAT_W + 1);
    localparam int RW = $clog2(RUN_LEN + 1);

    logic [PAT_W-1:0] hist_q;
    logic [PAT_W-1:0] hist_next;
    logic [FW-1:0]    fill_q;
    logic [RW-1:0]    run_q;
    logic             match_q;
    logic             will_be_full;

    // newest bit enters at the bottom; the top bit is the oldest
    assign hist_next    = {hist_q[PAT_W-2:0], bit_i};
    assign will_be_full = (fill_q >= FW'(PAT_W - 1));
    assign stop_o       = bit_i && (run_q == RW'(RUN_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hist_q  <= '0;
            fill_q  <= '0;
            run_q   <= '0;
            match_q <= 1'b0;
        end else begin
            match_q <= sample && will_be_full && (hist_next == pattern_i);
            if (sample) begin
                hist_q <= hist_next;
                fill_q <= FW'(sat_inc(int'(fill_q), PAT_W));
                run_q  <= bit_i ? RW'(sat_inc(int'(run_q), RUN_LEN)) : '0;
            end
        end
    end

    assign match_o = match_q;

    // R6: match flag is a single-cycle pulse
    a_r6_match_single: assert property (@(posedge clk) disable iff (rst)
        match_q |=> !match_q);

    // R8: a match needs a full history since the last start
    a_r8_match_needs_fill: assert property (@(posedge clk) disable iff (rst)
        match_q |-> (fill_q == FW'(PAT_W)));
endmodule

// File: rtl/serial_pattern_rx.sv
module serial_pattern_rx
    import spd_pkg::*;
#(
    parameter int OVS     = OVS_RATIO,
    parameter int PAT_W   = PATTERN_W,
    parameter int SYNC_N  = SYNC_DEPTH,
    parameter int RUN_LEN = END_RUN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_line,
    input  logic [PAT_W-1:0] pattern_i,
    output logic             start_o,
    output logic             match_o
);
    logic     line_s;
    logic     stop_req;
    seq_ctl_t ctl;

    line_sync #(.STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (rx_line),
        .d_sync  (line_s)
    );

    rx_sequencer #(.OVS(OVS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .line_s     (line_s),
        .stop_req   (stop_req),
        .ctl        (ctl),
        .start_flag (start_o)
    );

    bit_history #(.PAT_W(PAT_W), .RUN_LEN(RUN_LEN)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .clear     (ctl.confirm),
        .sample    (ctl.sample),
        .bit_i     (line_s),
        .pattern_i (pattern_i),
        .match_o   (match_o),
        .stop_o    (stop_req)
    );

    // R1: no flag while reset is held
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        $past(rst) |-> (!start_o && !match_o));
endmodule

// File: tb/tb_serial_pattern_rx.sv
module tb_serial_pattern_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic [3:0] pattern_i = 4'h0;
    logic       start_o, match_o;

    serial_pattern_rx dut (
        .clk       (clk),
        .rst       (rst),
        .rx_line   (rx_line),
        .pattern_i (pattern_i),
        .start_o   (start_o),
        .match_o   (match_o)
    );

    always #2.5 clk = ~clk;

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    int   c0     = 0;
    int   s_cnt  = 0;
    int   s_last = 0;
    int   z_bad  = 0;
    logic [15:0] z_mask = '0;
    bit   mon_en = 1'b0;
    bit   done   = 1'b0;

    // {pattern[3:0], data count[3:0], data bits[11:0] sent from bit 11 down}
    localparam int NVEC = 6;
    localparam logic [19:0] VEC [NVEC] = '{
        20'h6B6DA,   // 0110 on 01101101101 (R7)
        20'hB8B60,   // 1011 on 10110110
        20'h06000,   // 0000 on 000000 (R8)
        20'hF0000,   // 1111, no data: ending ones match (R10)
        20'h9A924,   // 1001 on 1001001001
        20'h3C333    // 0011 on 001100110011, ends early (R9)
    };

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mon_en) begin
            if (start_o) begin
                s_cnt  = s_cnt + 1;
                s_last = cyc;
            end
            if (match_o) begin
                int d;
                d = cyc - c0 - 5;
                if (d > 0 && (d % 4) == 0 && (d / 4) <= 16) z_mask[d/4-1] = 1'b1;
                else z_bad = z_bad + 1;
            end
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic mark();
        @(negedge clk);
        s_cnt  = 0;
        z_bad  = 0;
        z_mask = '0;
        c0     = cyc;
    endtask

    task automatic drive_bit(input logic b);
        rx_line = b;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_mask(input logic [3:0] pat, input int n,
                                             input logic [11:0] bits);
        logic [3:0]  h;
        int          fill, run;
        logic [15:0] m;
        h = '0; fill = 0; run = 0; m = '0;
        for (int k = 0; k < n + 4; k++) begin
            logic b;
            b    = (k < n) ? bits[11-k] : 1'b1;
            h    = {h[2:0], b};
            fill = (fill < 4) ? fill + 1 : 4;
            if (fill == 4 && h == pat) m[k] = 1'b1;
            run  = b ? run + 1 : 0;
            if (run == 4) break;
        end
        return m;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            report();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(start_o == 1'b0, "R1 start after reset", int'(start_o), 0);
        chk(match_o == 1'b0, "R1 match after reset", int'(match_o), 0);
        rst = 1'b0;
        mon_en = 1'b1;

        // R2: long idle on a high line
        mark();
        repeat (40) @(negedge clk);
        chk(s_cnt == 0, "R2 idle high line", s_cnt, 0);

        // R3: one-clock and two-clock lows are glitches
        pattern_i = 4'h0;
        mark();
        rx_line = 1'b0; @(negedge clk); rx_line = 1'b1;
        repeat (20) @(negedge clk);
        chk(s_cnt == 0, "R3 one-clock glitch", s_cnt, 0);
        mark();
        rx_line = 1'b0; repeat (2) @(negedge clk); rx_line = 1'b1;
        repeat (20) @(negedge clk);
        chk(s_cnt == 0, "R3 two-clock glitch", s_cnt, 0);

        // R3/R4: three-clock low is accepted, then ones end the stream
        mark();
        rx_line = 1'b0; repeat (3) @(negedge clk); rx_line = 1'b1;
        repeat (30) @(negedge clk);
        chk(s_cnt == 1, "R3 three-clock low accepted", s_cnt, 1);
        chk(s_last == c0 + 5, "R4 start flag cycle", s_last, c0 + 5);
        chk(z_mask == 16'h0 && z_bad == 0, "R8 no match on ones with 0000",
            int'(z_mask), 0);

        // R5 R6 R7 R8 R10: vector table
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0]  pat;
            int          n;
            logic [11:0] bits;
            logic [15:0] em;
            pat  = VEC[v][19:16];
            n    = int'(VEC[v][15:12]);
            bits = VEC[v][11:0];
            em   = exp_mask(pat, n, bits);
            pattern_i = pat;
            mark();
            drive_bit(1'b0);
            for (int k = 0; k < n; k++) drive_bit(bits[11-k]);
            for (int k = 0; k < 4; k++) drive_bit(1'b1);
            repeat (12) @(negedge clk);
            chk(s_cnt == 1 && s_last == c0 + 5, $sformatf("R4 vector %0d start", v),
                s_last, c0 + 5);
            chk(z_mask == em, $sformatf("R6 R7 R10 vector %0d match bits", v),
                int'(z_mask), int'(em));
            chk(z_bad == 0, $sformatf("R5 vector %0d match alignment", v), z_bad, 0);
        end

        // R9: idle after four ones, next low starts a fresh frame at once
        pattern_i = 4'h6;
        mark();
        drive_bit(1'b0);
        drive_bit(1'b1); drive_bit(1'b1); drive_bit(1'b1); drive_bit(1'b1);
        drive_bit(1'b0);
        drive_bit(1'b0); drive_bit(1'b1); drive_bit(1'b1); drive_bit(1'b0);
        for (int k = 0; k < 4; k++) drive_bit(1'b1);
        repeat (12) @(negedge clk);
        chk(s_cnt == 2, "R9 restart after ones", s_cnt, 2);
        chk(s_last == c0 + 25, "R9 second start cycle", s_last, c0 + 25);
        chk(z_mask == 16'h0100 && z_bad == 0, "R9 R8 match in second frame",
            int'(z_mask), 16'h0100);

        // R1: reset in mid-frame leaves nothing behind
        pattern_i = 4'hF;
        mark();
        drive_bit(1'b0);
        drive_bit(1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        mark();
        repeat (40) @(negedge clk);
        chk(s_cnt == 0 && z_mask == 16'h0 && z_bad == 0, "R1 mid-frame reset",
            int'(z_mask), 0);

        done = 1'b1;
        report();
        $finish;
    end
endmodule